// File: doc/BRIEF.md
# Dual-Context CRC Calculator

This block computes cyclic redundancy checks for two independent clients that share one register bus. Each context holds its own configuration, a running CRC value and a configuration-phase flag. Software picks, per context, either a 16-bit CCITT checksum or a 32-bit CRC. It can also have the result presented bit-reversed, complemented, or both.

A typical use runs in three steps. Software writes the status register with a seed, which also opens the configuration phase. It then writes the configuration word. After that it streams 32-bit words into the input register, one word per bus write, and each word is folded into the running CRC in a single clock cycle. The finished value is read from the status register (raw) or from the output register (post-processed). Read data is registered: it appears one clock after the address is presented.

Top module: `crc_dual_ctx`

## Requirements
- R1: After reset, every context register (configuration, input, status, output) reads 0.
- R2: Context k owns the byte offsets from k*0x10 to k*0x10+0xF. Within a context, the word at +0x0 is configuration, +0x4 is input, +0x8 is status and +0xC is output. Address bits [1:0] are ignored. The input register reads 0. Read data is valid on the clock after the address.
- R3: The configuration word has three fields. Bit 2 selects the polynomial (0 = CCITT 16-bit, 1 = CRC-32). Bit 1 enables bit-reversal and bit 0 enables inversion of the output. Bits [31:3] read 0.
- R4: A configuration write takes effect only while the context is in its configuration phase. Reset or a status write opens that phase, and the first input write closes it. A configuration write at any other time leaves the configuration unchanged.
- R5: A status write loads the written word as the seed of the running CRC. A status read returns the running value, with bits [31:16] reading 0 in CCITT mode.
- R6: In CRC-32 mode, an input write advances the running value by all 32 data bits, MSB first, with polynomial 0x04C11DB7. The result is visible on the next read.
- R7: In CCITT mode, an input write advances the low 16 bits by all 32 data bits, MSB first, with polynomial 0x1021.
- R8: The output register takes the value as read from status and applies two optional steps. With swap set, it bit-reverses the value (only bits [15:0] in CCITT mode). With invert set, it then complements the value (only bits [15:0] in CCITT mode). Bits [31:16] are 0 in CCITT mode.
- R9: A write to one context never changes any register of the other context.
- R10: Offsets 0x20 and above read 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
Two functions meet in one cycle when an input write is accepted. That write both steps the CRC and closes the configuration phase, so a configuration write issued straight after it must be refused. The random stream mixes configuration, seed and input writes to both contexts in any order, so configuration writes land both inside and outside the phase. Every read is compared against a bench model that tracks the phase flag, the seed and the MSB-first polynomial step on its own.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] POLY_32 = 32'h04C1_1DB7;
  localparam logic [15:0] POLY_16 = 16'h1021;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_IN   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_OUT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wide;   // 1: 32-bit polynomial, 0: 16-bit CCITT
    logic swap;   // bit-reverse output
    logic inv;    // complement output
  } crc_cfg_t;
endpackage

// File: rtl/crc_step.sv
module crc_step
  import crc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [31:0]       state,
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  output logic [31:0]       next
);
  logic [31:0] s32 [DATA_W+1];
  logic [15:0] s16 [DATA_W+1];

  assign s32[0] = state;
  assign s16[0] = state[15:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb32, fb16;
    assign fb32 = s32[i][31] ^ data[DATA_W-1-i];
    assign fb16 = s16[i][15] ^ data[DATA_W-1-i];
    assign s32[i+1] = {s32[i][30:0], 1'b0} ^ ({32{fb32}} & POLY_32);
    assign s16[i+1] = {s16[i][14:0], 1'b0} ^ ({16{fb16}} & POLY_16);
  end

  assign next = wide ? s32[DATA_W] : {16'h0000, s16[DATA_W]};
endmodule

// File: rtl/crc_outfmt.sv
module crc_outfmt
  import crc_pkg::*;
(
  input  logic [31:0] raw,
  input  crc_cfg_t    cfg,
  output logic [31:0] view,
  output logic [31:0] post
);
  logic [31:0] rev32;
  logic [15:0] rev16;
  logic [31:0] swapped;

  for (genvar i = 0; i < 32; i++) begin : g_rev32
    assign rev32[i] = raw[31-i];
  end
  for (genvar j = 0; j < 16; j++) begin : g_rev16
    assign rev16[j] = raw[15-j];
  end

  always_comb begin
    view = cfg.wide ? raw : {16'h0000, raw[15:0]};
    if (cfg.swap)
      swapped = cfg.wide ? rev32 : {16'h0000, rev16};
    else
      swapped = view;
    if (cfg.inv)
      post = swapped ^ (cfg.wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    else
      post = swapped;
  end
endmodule

// File: rtl/crc_context.sv
module crc_context
  import crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        in_we,
  input  logic        stat_we,
  input  logic [31:0] wdata,
  output crc_cfg_t    cfg_q,
  output logic [31:0] stat_val,
  output logic [31:0] out_val
);
  logic [31:0] crc_q;
  logic        phase_q;
  logic [31:0] crc_nx;

  crc_step #(.DATA_W(WORD_W)) u_step (
    .state (crc_q),
    .data  (wdata),
    .wide  (cfg_q.wide),
    .next  (crc_nx)
  );

  crc_outfmt u_fmt (
    .raw  (crc_q),
    .cfg  (cfg_q),
    .view (stat_val),
    .post (out_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= '0;
      cfg_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      if (stat_we) begin
        crc_q   <= wdata;
        phase_q <= 1'b1;
      end else if (in_we) begin
        crc_q   <= crc_nx;
        phase_q <= 1'b0;
      end
      if (cfg_we && phase_q)
        cfg_q <= crc_cfg_t'(wdata[2:0]);
    end
  end

  // R4: configuration is frozen outside the configuration phase
  a_r4_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !phase_q) |=> $stable(cfg_q));

  // R4: first input write closes the phase
  a_r4_phase_closes: assert property (@(posedge clk) disable iff (rst)
    (in_we && !stat_we) |=> !phase_q);

  // R5: a seed write opens the phase and is visible on status
  a_r5_seed_loaded: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> (phase_q && crc_q == $past(wdata)));

  // R8: CCITT mode keeps the upper half of status and output clear
  a_r8_upper_clear: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.wide |-> (stat_val[31:16] == 16'h0 && out_val[31:16] == 16'h0));

  // R9: a context with no write strobe keeps all of its state
  a_r9_isolated: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we || in_we || stat_we) |=> ($stable(crc_q) && $stable(cfg_q) && $stable(phase_q)));
endmodule

// File: rtl/crc_dual_ctx.sv
module crc_dual_ctx
  import crc_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned NCTX   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned CTX_W    = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int unsigned SPAN_LSB = 4;

  logic             in_range;
  logic [CTX_W-1:0] ctx_sel;
  reg_sel_e         reg_sel;
  logic [31:0]      rd_mux;
  logic             unused_lowbits;

  crc_cfg_t    cfg_v  [NCTX];
  logic [31:0] stat_v [NCTX];
  logic [31:0] out_v  [NCTX];

  assign in_range       = bus_addr < ADDR_W'(NCTX * 16);
  assign ctx_sel        = bus_addr[SPAN_LSB +: CTX_W];
  assign reg_sel        = reg_sel_e'(bus_addr[3:2]);
  assign unused_lowbits = ^bus_addr[1:0];

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    logic hit;
    assign hit = bus_wr && in_range && (ctx_sel == CTX_W'(k));
    crc_context u_ctx (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (hit && reg_sel == SEL_CFG),
      .in_we    (hit && reg_sel == SEL_IN),
      .stat_we  (hit && reg_sel == SEL_STAT),
      .wdata    (bus_wdata),
      .cfg_q    (cfg_v[k]),
      .stat_val (stat_v[k]),
      .out_val  (out_v[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (reg_sel)
        SEL_CFG:  rd_mux = {29'h0, cfg_v[ctx_sel]};
        SEL_IN:   rd_mux = '0;
        SEL_STAT: rd_mux = stat_v[ctx_sel];
        SEL_OUT:  rd_mux = out_v[ctx_sel];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R10: reserved offsets read as zero on the following cycle
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> bus_rdata == 32'h0);

  // R3: configuration reads never show reserved bits
  a_r3_cfg_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_range && reg_sel == SEL_CFG) |=> bus_rdata[31:3] == 29'h0);

  // R2: the input register reads zero
  a_r2_input_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (in_range && reg_sel == SEL_IN) |=> bus_rdata == 32'h0);
endmodule

// File: tb/tb_crc_dual_ctx.sv
`timescale 1ns/1ps
module tb_crc_dual_ctx;
  localparam int ADDR_W = 14;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [2:0]  m_cfg   [2];
  logic [31:0] m_crc   [2];
  bit          m_phase [2];

  crc_dual_ctx #(.ADDR_W(ADDR_W), .NCTX(2)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] m32(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [15:0] m16(input logic [15:0] c, input logic [31:0] d);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_stat(input int k);
    return m_cfg[k][2] ? m_crc[k] : {16'h0, m_crc[k][15:0]};
  endfunction

  function automatic logic [31:0] exp_out(input int k);
    logic [31:0] v = exp_stat(k);
    logic [31:0] s = v;
    if (m_cfg[k][1]) begin
      s = '0;
      if (m_cfg[k][2]) for (int i = 0; i < 32; i++) s[i] = v[31-i];
      else             for (int i = 0; i < 16; i++) s[i] = v[15-i];
    end
    if (m_cfg[k][0]) s = s ^ (m_cfg[k][2] ? 32'hFFFFFFFF : 32'h0000FFFF);
    return s;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int k;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 14'h20) begin
      k = int'(a[4]);
      case (a[3:2])
        2'd0: if (m_phase[k]) m_cfg[k] = d[2:0];
        2'd1: begin
          m_crc[k] = m_cfg[k][2] ? m32(m_crc[k], d) : {16'h0, m16(m_crc[k][15:0], d)};
          m_phase[k] = 1'b0;
        end
        2'd2: begin m_crc[k] = d; m_phase[k] = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic rd_check(input logic [ADDR_W-1:0] a, input string tag);
    logic [31:0] v, e;
    int k;
    rd(a, v);
    if (a >= 14'h20) e = 32'h0;
    else begin
      k = int'(a[4]);
      case (a[3:2])
        2'd0: e = {29'h0, m_cfg[k]};
        2'd1: e = 32'h0;
        2'd2: e = exp_stat(k);
        default: e = exp_out(k);
      endcase
    end
    check(v, e, tag);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 32; a += 4) rd_check(14'(a), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_C0DE));
    for (int k = 0; k < 2; k++) begin m_cfg[k] = '0; m_crc[k] = '0; m_phase[k] = 1'b1; end
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register
    check_all("R1 reset");

    // R3 R8 R6: CRC-32 with swap and invert in context 0
    wr(14'h08, 32'hFFFFFFFF);
    wr(14'h00, 32'hFFFF_FFFF);
    rd_check(14'h00, "R3 cfg upper bits");
    wr(14'h04, 32'h31323334);
    rd_check(14'h08, "R6 crc32 step");
    rd_check(14'h0C, "R8 swap+inv 32");

    // R4: config write after input is ignored
    wr(14'h00, 32'h0);
    rd_check(14'h00, "R4 cfg locked");
    rd_check(14'h0C, "R4 output unchanged");

    // R7 R8 R9: CCITT with swap only in context 1
    wr(14'h18, 32'hABCD1234);
    rd_check(14'h18, "R5 seed ccitt upper zero");
    wr(14'h10, 32'h2);
    wr(14'h14, 32'hDEADBEEF);
    rd_check(14'h18, "R7 ccitt step");
    rd_check(14'h1C, "R8 swap 16");
    rd_check(14'h08, "R9 ctx0 untouched");

    // R2: low address bits ignored
    rd_check(14'h1B, "R2 byte alias");
    rd_check(14'h05, "R2 input reads zero");

    // R10: reserved writes and reads
    wr(14'h20, 32'hFFFFFFFF);
    wr(14'h3FF8, 32'h12345678);
    rd_check(14'h20, "R10 reserved read");
    rd_check(14'h3FFC, "R10 reserved high");
    check_all("R10 no side effect");

    // R4: status write reopens the phase
    wr(14'h08, 32'h0);
    wr(14'h00, 32'h1);
    rd_check(14'h00, "R4 phase reopened");
    rd_check(14'h0C, "R8 inv only ccitt");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      logic [ADDR_W-1:0] base = $urandom_range(0, 1) ? 14'h10 : 14'h00;
      logic [1:0] lo = 2'($urandom_range(0, 3));
      logic [31:0] d = $urandom;
      case (op)
        0: wr(base | 14'h0 | 14'(lo), d);
        1, 2: wr(base | 14'h8, d);
        3, 4, 5: wr(base | 14'h4, d);
        6: rd_check(base | 14'h0 | 14'(lo), "R3 R4 random cfg");
        7: rd_check(base | 14'h8, "R5 R6 R7 random status");
        8: rd_check(base | 14'hC | 14'(lo), "R8 random output");
        default: rd_check(base ^ 14'h10 | 14'h8, "R9 random other ctx");
      endcase
    end
    check_all("R9 final sweep");

    rd(14'h00, v);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule